// File: doc/BRIEF.md
# Receive Descriptor Ownership Poll Scheduler

This block decides when the receive path reads the ownership bit of descriptors in a circular receive ring. It tracks two ring slots, the current one and the one after it, and keeps a flag for each that says whether the controller holds that descriptor. When either flag is clear it issues poll requests that name a ring index. Each request completes when the memory side returns a response that carries the ownership bit. Once both slots are held, polling stops until the pointer moves on.

Several things set the polling rate. When receive data is waiting and the current slot is not held, one poll goes out at once, and further polls follow at a short channel interval. When the receive FIFO is empty, polls follow at the longer transmit interval. A demand strobe forces a poll straight away. A frame-complete strobe advances the ring pointer and shifts the ownership flags. Only one poll is outstanding at any time.

Top module: `rx_poll_sched`

## Requirements
- R1: While `cur_owned` is 1 and either `nxt_owned` is 1 or the ring length is 1, `poll_req` stays low.
- R2: With `ring_len` equal to 1, every poll names the current index and `nxt_owned` stays 0.
- R3: When `fifo_has_data` rises while the current slot is not held, `poll_req` rises on the next clock edge. No interval is waited.
- R4: While `fifo_has_data` is 1 and a poll returns ownership 0, the next request rises `chan_poll_int`+1 cycles after the response cycle.
- R5: A one-cycle `demand_poll` pulse while idle and not fully owned raises `poll_req` on the next edge, whatever the timer holds.
- R6: While `fifo_has_data` is 0 and fewer than two slots are held, the next request rises `xmit_poll_int`+1 cycles after the previous response.
- R7: A `frame_done` pulse moves `cur_idx` to the next ring index. It copies the old `nxt_owned` into `cur_owned` and clears `nxt_owned`.
- R8: The ring index after `ring_len`-1 is 0, both for the advance and for the next-slot poll target.
- R9: A poll names `cur_idx` when the current slot is not held. Otherwise it names the next ring index.
- R10: `poll_req` and `poll_idx` stay unchanged until `poll_ack`. A demand that arrives during an outstanding poll is served by a request one idle cycle after the response.
- R11: On `poll_ack`, `poll_own` becomes the ownership flag of whichever slot `poll_idx` names.
- R12: After reset, `poll_req`, `cur_owned` and `nxt_owned` are 0 and `cur_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_has_data | input | 1 | Receive data waits to be written to memory |
| demand_poll | input | 1 | One-cycle request for an immediate poll |
| frame_done | input | 1 | One-cycle strobe: the current frame has completed |
| ring_len | input | IDX_W+1 | Number of ring entries, 1 to 2**IDX_W |
| chan_poll_int | input | TMR_W | Poll interval in cycles while data waits |
| xmit_poll_int | input | TMR_W | Poll interval in cycles while the FIFO is empty |
| poll_req | output | 1 | A poll is requested or outstanding |
| poll_idx | output | IDX_W | Ring index of the requested poll |
| poll_ack | input | 1 | Response for the outstanding poll |
| poll_own | input | 1 | Ownership bit returned with the response |
| cur_owned | output | 1 | Controller holds the current descriptor |
| nxt_owned | output | 1 | Controller holds the next descriptor |
| cur_idx | output | IDX_W | Current ring index |

## Verification
The bench builds the block with IDX_W=3 and TMR_W=8. The 3-bit index lets a ring of four entries wrap within a few frame strobes. The 8-bit intervals (5 and 20 cycles, 100 for a quiet case) let both rates and the exact request spacing be measured cycle by cycle. A second reset with a ring length of 1 reaches the single-entry case, where the next slot never exists.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  typedef enum logic [0:0] {
    RXP_IDLE = 1'b0,
    RXP_WAIT = 1'b1
  } rxp_state_e;

  typedef struct packed {
    logic cur;
    logic nxt;
  } rxp_own_t;

endpackage

// File: rtl/rxp_ring_ptr.sv
module rxp_ring_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W:0]   ring_len,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             single
);

  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W:0]   cur_plus;

  always_comb begin
    cur_plus = {1'b0, cur_q} + 1'b1;
    if (cur_plus >= ring_len) begin
      nxt_idx = '0;
    end else begin
      nxt_idx = cur_plus[IDX_W-1:0];
    end
    single = (ring_len <= 1);
  end

  always_comb begin
    cur_d = cur_q;
    if (advance) begin
      cur_d = nxt_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (advance) begin
      cur_q <= cur_d;
    end
  end

  assign cur_idx = cur_q;

  AST_PTR_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cur_idx == '0) || (cur_idx == $past(cur_idx) + 1'b1)); // R8

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(cur_idx)); // R7

endmodule

// File: rtl/rxp_elapsed_timer.sv
module rxp_elapsed_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [TMR_W-1:0] interval,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_en && (cnt_q != '1)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_ce = clr | cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q >= interval);

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/rxp_poll_ctrl.sv
module rxp_poll_ctrl
  import rxp_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_has_data,
  input  logic             demand_poll,
  input  logic             frame_done,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] nxt_idx,
  input  logic             single,
  input  logic             timer_expired,
  input  logic             poll_ack,
  input  logic             poll_own,
  output logic             poll_req,
  output logic [IDX_W-1:0] poll_idx,
  output logic             cur_owned,
  output logic             nxt_owned,
  output logic             timer_clr,
  output logic             timer_en
);

  rxp_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  rxp_own_t         own_q, own_d;
  logic             dem_pend_q, dem_pend_d;
  logic             imm_done_q, imm_done_d;

  logic need_cur, need_nxt, need_any;
  logic imm_cond, go, idle, done;

  // Demand and need decode
  always_comb begin
    idle     = (state_q == RXP_IDLE);
    done     = (state_q == RXP_WAIT) && poll_ack;
    need_cur = !own_q.cur;
    need_nxt = !single && !own_q.nxt;
    need_any = need_cur || need_nxt;
    imm_cond = fifo_has_data && !own_q.cur;
    go       = idle && need_any &&
               (demand_poll || dem_pend_q || (imm_cond && !imm_done_q) || timer_expired);
  end

  // Request state and target index
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (go) begin
      state_d = RXP_WAIT;
      idx_d   = need_cur ? cur_idx : nxt_idx;
    end else if (done) begin
      state_d = RXP_IDLE;
    end
  end

  // Ownership flags: response first, then the advance shift
  always_comb begin
    own_d = own_q;
    if (done) begin
      if (idx_q == cur_idx) begin
        own_d.cur = poll_own;
      end else if (!single && (idx_q == nxt_idx)) begin
        own_d.nxt = poll_own;
      end
    end
    if (frame_done) begin
      own_d.cur = own_d.nxt;
      own_d.nxt = 1'b0;
    end
  end

  // Remembered demand and immediate-poll tracking
  always_comb begin
    dem_pend_d = dem_pend_q | demand_poll;
    if (go || (idle && !need_any)) begin
      dem_pend_d = 1'b0;
    end
    imm_done_d = imm_done_q;
    if (!imm_cond) begin
      imm_done_d = 1'b0;
    end else if (go) begin
      imm_done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RXP_IDLE;
      idx_q      <= '0;
      own_q      <= '0;
      dem_pend_q <= 1'b0;
      imm_done_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (go) begin
        idx_q <= idx_d;
      end
      if (done || frame_done) begin
        own_q <= own_d;
      end
      dem_pend_q <= dem_pend_d;
      imm_done_q <= imm_done_d;
    end
  end

  assign poll_req  = (state_q == RXP_WAIT);
  assign poll_idx  = idx_q;
  assign cur_owned = own_q.cur;
  assign nxt_owned = own_q.nxt;
  assign timer_clr = !idle || !need_any || go;
  assign timer_en  = !timer_clr;

  AST_NO_POLL_BOTH_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_req && cur_owned && (nxt_owned || single)) |=> !poll_req); // R1

  AST_LEN1_CUR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(poll_req) && $past(single)) |-> (poll_idx == $past(cur_idx))); // R2

  AST_DEMAND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (demand_poll && !poll_req && need_any) |=> poll_req); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req && !poll_ack) |=> (poll_req && $stable(poll_idx))); // R10

  AST_NXT_CLEARED_ON_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !nxt_owned); // R7

endmodule

// File: rtl/rx_poll_sched.sv
module rx_poll_sched #(
  parameter int IDX_W = 7,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_has_data,
  input  logic             demand_poll,
  input  logic             frame_done,
  input  logic [IDX_W:0]   ring_len,
  input  logic [TMR_W-1:0] chan_poll_int,
  input  logic [TMR_W-1:0] xmit_poll_int,
  output logic             poll_req,
  output logic [IDX_W-1:0] poll_idx,
  input  logic             poll_ack,
  input  logic             poll_own,
  output logic             cur_owned,
  output logic             nxt_owned,
  output logic [IDX_W-1:0] cur_idx
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [IDX_W-1:0] nxt_idx;
  logic             single;
  logic             timer_expired;
  logic             timer_clr;
  logic             timer_en;
  logic [TMR_W-1:0] interval;

  assign interval = fifo_has_data ? chan_poll_int : xmit_poll_int;

  rxp_ring_ptr #(.IDX_W(IDX_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ring_len (ring_len),
    .advance  (frame_done),
    .cur_idx  (cur_idx),
    .nxt_idx  (nxt_idx),
    .single   (single)
  );

  rxp_elapsed_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (timer_clr),
    .cnt_en   (timer_en),
    .interval (interval),
    .expired  (timer_expired)
  );

  rxp_poll_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .fifo_has_data (fifo_has_data),
    .demand_poll   (demand_poll),
    .frame_done    (frame_done),
    .cur_idx       (cur_idx),
    .nxt_idx       (nxt_idx),
    .single        (single),
    .timer_expired (timer_expired),
    .poll_ack      (poll_ack),
    .poll_own      (poll_own),
    .poll_req      (poll_req),
    .poll_idx      (poll_idx),
    .cur_owned     (cur_owned),
    .nxt_owned     (nxt_owned),
    .timer_clr     (timer_clr),
    .timer_en      (timer_en)
  );

endmodule

// File: tb/tb_rx_poll_sched.sv
module tb_rx_poll_sched;

  localparam int IDX_W = 3;
  localparam int TMR_W = 8;
  localparam int CHAN  = 5;
  localparam int XMIT  = 20;

  logic             clk;
  logic             rst_n;
  logic             fifo_has_data;
  logic             demand_poll;
  logic             frame_done;
  logic [IDX_W:0]   ring_len;
  logic [TMR_W-1:0] chan_poll_int;
  logic [TMR_W-1:0] xmit_poll_int;
  logic             poll_req;
  logic [IDX_W-1:0] poll_idx;
  logic             poll_ack;
  logic             poll_own;
  logic             cur_owned;
  logic             nxt_owned;
  logic [IDX_W-1:0] cur_idx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  rx_poll_sched #(.IDX_W(IDX_W), .TMR_W(TMR_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_has_data (fifo_has_data),
    .demand_poll   (demand_poll),
    .frame_done    (frame_done),
    .ring_len      (ring_len),
    .chan_poll_int (chan_poll_int),
    .xmit_poll_int (xmit_poll_int),
    .poll_req      (poll_req),
    .poll_idx      (poll_idx),
    .poll_ack      (poll_ack),
    .poll_own      (poll_own),
    .cur_owned     (cur_owned),
    .nxt_owned     (nxt_owned),
    .cur_idx       (cur_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int len, input int xint);
    rst_n         = 1'b0;
    fifo_has_data = 1'b0;
    demand_poll   = 1'b0;
    frame_done    = 1'b0;
    poll_ack      = 1'b0;
    poll_own      = 1'b0;
    ring_len      = len[IDX_W:0];
    chan_poll_int = CHAN[TMR_W-1:0];
    xmit_poll_int = xint[TMR_W-1:0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_req(input int limit, output int n);
    n = 0;
    while (!poll_req && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic respond(input logic own);
    poll_ack = 1'b1;
    poll_own = own;
    @(negedge clk);
    poll_ack = 1'b0;
    poll_own = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(4, XMIT);
    chk("R12 poll_req", poll_req, 0);
    chk("R12 cur_owned", cur_owned, 0);
    chk("R12 nxt_owned", nxt_owned, 0);
    chk("R12 cur_idx", cur_idx, 0);
  endtask

  task automatic t_xmit_rate_and_targets();
    int n;
    wait_req(100, n);
    chk("R9 first target current", poll_idx, 0);
    respond(1'b0);
    wait_req(100, n);
    chk("R6 transmit interval spacing", n, XMIT + 1);
    respond(1'b1);
    chk("R11 current flag from response", cur_owned, 1);
    wait_req(100, n);
    chk("R9 then next target", poll_idx, 1);
    respond(1'b1);
    chk("R11 next flag from response", nxt_owned, 1);
    wait_req(60, n);
    chk("R1 no poll when both owned", poll_req, 0);
  endtask

  task automatic t_advance();
    pulse_frame();
    chk("R7 index advanced", cur_idx, 1);
    chk("R7 old next flag moved", cur_owned, 1);
    chk("R7 next flag cleared", nxt_owned, 0);
  endtask

  task automatic t_demand();
    int n;
    wait_req(100, n);
    chk("R9 target after advance", poll_idx, 2);
    respond(1'b0);
    demand_poll = 1'b1;
    @(negedge clk);
    demand_poll = 1'b0;
    chk("R5 demand poll immediate", poll_req, 1);
    chk("R5 demand poll index", poll_idx, 2);
    respond(1'b1);
    chk("R11 next owned after demand", nxt_owned, 1);
  endtask

  task automatic t_outstanding();
    int n;
    pulse_frame();
    wait_req(100, n);
    chk("R9 next target idx 3", poll_idx, 3);
    repeat (3) @(negedge clk);
    chk("R10 request held", poll_req, 1);
    chk("R10 index held", poll_idx, 3);
    demand_poll = 1'b1;
    @(negedge clk);
    demand_poll = 1'b0;
    respond(1'b0);
    chk("R10 low after response", poll_req, 0);
    @(negedge clk);
    chk("R10 remembered demand served", poll_req, 1);
    respond(1'b1);
  endtask

  task automatic t_wrap();
    int n;
    pulse_frame();
    chk("R7 index 3", cur_idx, 3);
    wait_req(100, n);
    chk("R8 next target wraps to 0", poll_idx, 0);
    respond(1'b1);
    pulse_frame();
    chk("R8 index wraps to 0", cur_idx, 0);
    chk("R7 flag shifted on wrap", cur_owned, 1);
  endtask

  task automatic t_immediate_and_chan();
    int n;
    do_reset(4, 100);
    repeat (3) @(negedge clk);
    chk("R6 no early poll", poll_req, 0);
    fifo_has_data = 1'b1;
    @(negedge clk);
    chk("R3 immediate poll on data", poll_req, 1);
    chk("R3 immediate poll names current", poll_idx, 0);
    respond(1'b0);
    wait_req(100, n);
    chk("R4 channel interval spacing", n, CHAN + 1);
    respond(1'b0);
    wait_req(100, n);
    chk("R4 channel interval repeat", n, CHAN + 1);
    respond(1'b1);
    fifo_has_data = 1'b0;
  endtask

  task automatic t_single();
    int n;
    do_reset(1, 10);
    wait_req(50, n);
    chk("R2 single ring polls current", poll_idx, 0);
    respond(1'b1);
    wait_req(50, n);
    chk("R2 no poll once current owned", poll_req, 0);
    chk("R2 next flag stays clear", nxt_owned, 0);
    pulse_frame();
    chk("R8 single ring index stays 0", cur_idx, 0);
    chk("R7 single ring flag from empty next", cur_owned, 0);
    wait_req(50, n);
    chk("R2 repoll current index", poll_idx, 0);
    respond(1'b1);
  endtask

  initial begin
    t_reset_state();
    t_xmit_rate_and_targets();
    t_advance();
    t_demand();
    t_outstanding();
    t_wrap();
    t_immediate_and_chan();
    t_single();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule